// File: doc/BRIEF.md
# Cartridge ROM Bank-Select Latch

This block forms the full ROM address for a plug-in cartridge whose processor sees only an 8 KB window. The bank number is taken from the processor's address lines, not its data lines: when software writes anywhere in the window, a few low address bits are captured, and the captured bank then drives the upper ROM address lines. The low 13 bits of the processor address always pass straight through as the offset inside the selected 8 KB bank. Decoding the window is done outside; the block receives an active-low window select.

The captured value is taken when the active-low write strobe returns high, that is, at the end of the write cycle, and only if the window select was low during the write. The byte-select line (the least significant address bit) is left out, because it toggles within every word access. In the default inverted mode, the bank lines are the bitwise complement of the stored value. A write at window offset 0 then selects the topmost bank, which matches older cartridge images. In true mode, images are laid out from ROM address 0. A parameter sets the bank width to 4, 5 or 6 bits, covering ROMs from 128 KB to 512 KB. Any ROM address lines above the configured width are driven low.

Top module: `rom_page_latch`

## Requirements
- R1: After reset the stored bank is zero: with `inv_mode`=1 every configured bank line of `rom_addr` reads 1, and with `inv_mode`=0 every bank line reads 0.
- R2: When `wr_n` rises while `sel_n` was low during the write, the stored bank becomes `cpu_ofs[BANK_BITS:1]`, with `cpu_ofs[1]` as the least significant bank bit. Bit 0 of the address does not take part, so writes at 0x006 and 0x007 select the same bank.
- R3: A write strobe with `sel_n` high leaves the stored bank unchanged.
- R4: While `wr_n` is still low, the stored bank has not yet changed. The new bank appears only after the trailing edge of the strobe.
- R5: Reads in the window (`sel_n` low, `wr_n` high) leave the stored bank unchanged.
- R6: `rom_addr[13 +: BANK_BITS]` equals the bitwise complement of the stored bank when `inv_mode`=1, and equals the stored bank when `inv_mode`=0. With `inv_mode`=1, a write at offset 0x01E (bank 15) gives all-zero bank lines for `BANK_BITS`=4.
- R7: `rom_addr[12:0]` always equals `cpu_ofs[12:0]`, combinationally.
- R8: `rom_addr` bits at positions 13+`BANK_BITS` and above are always 0.
- R9: With `BANK_BITS`=6, the address bits `cpu_ofs[6:5]` are also captured, so that any of 64 banks can be selected. A write at 0x07E selects bank 63, and a write at 0x040 selects bank 32.
- R10: The stored bank holds indefinitely between qualifying writes. Changing `inv_mode` alters only the output mapping, never the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low cartridge window select |
| wr_n | input | 1 | Active-low write strobe; its trailing edge loads the bank |
| cpu_ofs | input | 13 | Processor address bits within the 8 KB window |
| inv_mode | input | 1 | 1 = complemented bank lines, 0 = true bank lines |
| rom_addr | output | 19 | Full ROM address: bank above bit 12, offset below |

## Verification
The hardest case to reach is the interval inside a write, after the strobe has fallen but before it rises again. At that point the address bus already carries the new bank number, yet the output must still show the old one. Every bank write in the bench samples the output during this interval, then samples it again after the trailing edge. A second instance with six bank bits runs on the same stimulus, so the wide capture and the zeroing of the upper lines are both checked by every write.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
    localparam int OFS_BITS      = 13;
    localparam int MAX_BANK_BITS = 6;
    localparam int ROM_AW        = OFS_BITS + MAX_BANK_BITS;
endpackage

// File: rtl/rpl_edge_qual.sv
module rpl_edge_qual #(
    parameter int BANK_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n,
    input  logic                 wr_n,
    input  logic [BANK_BITS-1:0] bank_in,
    output logic                 load,
    output logic [BANK_BITS-1:0] cap_bank
);
    typedef struct packed {
        logic                 wr;
        logic                 sel;
        logic [BANK_BITS-1:0] bank;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.wr   = wr_n;
        s_d.sel  = sel_n;
        s_d.bank = bank_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wr: 1'b1, sel: 1'b1, bank: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // trailing strobe edge, window selected while the strobe was low
    assign load     = !s_q.wr && wr_n && !s_q.sel;
    assign cap_bank = s_q.bank;
endmodule

// File: rtl/rpl_addr_map.sv
module rpl_addr_map
    import rpl_pkg::*;
#(
    parameter int BANK_BITS = 4
) (
    input  logic [BANK_BITS-1:0] bank,
    input  logic                 inv_mode,
    input  logic [OFS_BITS-1:0]  ofs,
    output logic [ROM_AW-1:0]    rom_addr
);
    logic [BANK_BITS-1:0] bank_lines;

    assign bank_lines = inv_mode ? ~bank : bank;
    assign rom_addr[OFS_BITS-1:0] = ofs;
    assign rom_addr[OFS_BITS +: BANK_BITS] = bank_lines;

    generate
        if (BANK_BITS < MAX_BANK_BITS) begin : g_pad
            assign rom_addr[ROM_AW-1:OFS_BITS+BANK_BITS] = '0;
        end
    endgenerate
endmodule

// File: rtl/rom_page_latch.sv
module rom_page_latch
    import rpl_pkg::*;
#(
    parameter int BANK_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                wr_n,
    input  logic [12:0]         cpu_ofs,
    input  logic                inv_mode,
    output logic [18:0]         rom_addr
);
    typedef struct packed {
        logic [BANK_BITS-1:0] bank;
    } state_t;

    state_t               st_d, st_q;
    logic                 load;
    logic [BANK_BITS-1:0] cap_bank;
    logic [BANK_BITS-1:0] bank_q;

    rpl_edge_qual #(.BANK_BITS(BANK_BITS)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .wr_n     (wr_n),
        .bank_in  (cpu_ofs[BANK_BITS:1]),
        .load     (load),
        .cap_bank (cap_bank)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bank = cap_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q = st_q.bank;

    rpl_addr_map #(.BANK_BITS(BANK_BITS)) u_map (
        .bank     (bank_q),
        .inv_mode (inv_mode),
        .ofs      (cpu_ofs),
        .rom_addr (rom_addr)
    );
endmodule

// File: rtl/rom_page_latch_chk.sv
module rom_page_latch_chk #(
    parameter int BANK_BITS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel_n,
    input logic                 wr_n,
    input logic [12:0]          cpu_ofs,
    input logic [18:0]          rom_addr,
    input logic [BANK_BITS-1:0] bank_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> bank_q == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && !$past(wr_n) && !$past(sel_n))
        |=> bank_q == $past(cpu_ofs[BANK_BITS:1], 2));

    // R3 R4 R5 R10
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_n && !$past(wr_n) && !$past(sel_n)) |=> $stable(bank_q));

    // R7
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[12:0] == cpu_ofs);

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr >> (13 + BANK_BITS)) == 19'd0);
endmodule

bind rom_page_latch rom_page_latch_chk #(.BANK_BITS(BANK_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .wr_n     (wr_n),
    .cpu_ofs  (cpu_ofs),
    .rom_addr (rom_addr),
    .bank_q   (bank_q)
);

// File: tb/rom_page_latch_test.sv
module rom_page_latch_test;
    logic        clk = 1'b0;
    logic        rst_n, sel_n, wr_n, inv_mode;
    logic [12:0] cpu_ofs;
    logic [18:0] rom4, rom6;
    logic [5:0]  m4, m6;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    typedef struct {
        string       tag;
        logic [18:0] e4;
        logic [18:0] e6;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #4 clk = ~clk;

    rom_page_latch uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .cpu_ofs(cpu_ofs), .inv_mode(inv_mode), .rom_addr(rom4)
    );

    rom_page_latch #(.BANK_BITS(6)) uut_wide (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .cpu_ofs(cpu_ofs), .inv_mode(inv_mode), .rom_addr(rom6)
    );

    function automatic logic [18:0] model(int bb, logic [5:0] bank,
                                          logic inv, logic [12:0] ofs);
        logic [5:0] msk, v;
        msk = 6'((1 << bb) - 1);
        v   = (inv ? ~bank : bank) & msk;
        return {v, ofs};
    endfunction

    task automatic push_check(input string tag);
        item_t it;
        #2;
        it.tag = tag;
        it.e4  = model(4, m4, inv_mode, cpu_ofs);
        it.e6  = model(6, m6, inv_mode, cpu_ofs);
        sb_q.push_back(it);
        -> sample_ev;
        #0;
    endtask

    task automatic read_at(input logic [12:0] a, input string tag);
        @(negedge clk);
        cpu_ofs = a; sel_n = 1'b0; wr_n = 1'b1;
        push_check(tag);
        @(negedge clk);
        sel_n = 1'b1;
    endtask

    task automatic write_bank(input logic [12:0] a, input logic s, input string tag);
        @(negedge clk);
        cpu_ofs = a; sel_n = s; wr_n = 1'b0;
        push_check({"R4 strobe low, old bank kept / ", tag});
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        sel_n = 1'b1;
        if (!s) begin
            m4 = 6'((a >> 1) & 13'hF);
            m6 = 6'((a >> 1) & 13'h3F);
        end
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_chk++;
                if (rom4 !== it.e4) begin
                    n_fail++;
                    $display("FAIL %s (4-bit): actual %h expected %h", it.tag, rom4, it.e4);
                end
                n_chk++;
                if (rom6 !== it.e6) begin
                    n_fail++;
                    $display("FAIL %s (6-bit): actual %h expected %h", it.tag, rom6, it.e6);
                end
            end
        end
    end

    initial begin : stim
        rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; inv_mode = 1'b1; cpu_ofs = '0;
        m4 = '0; m6 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        read_at(13'h0000, "R1 reset bank inverted");
        read_at(13'h1FFE, "R7 offset passthrough");
        @(negedge clk); inv_mode = 1'b0;
        read_at(13'h0000, "R1 reset bank true mode");
        read_at(13'h0ABC, "R6 R7 true mode offset");
        @(negedge clk); inv_mode = 1'b1;

        write_bank(13'h0006, 1'b0, "R2");
        read_at(13'h0100, "R2 bank 3 inverted");
        write_bank(13'h0007, 1'b0, "R2 odd");
        read_at(13'h0100, "R2 byte line excluded");
        write_bank(13'h001E, 1'b0, "R6");
        read_at(13'h0000, "R6 bank 15 gives zero lines");
        write_bank(13'h007E, 1'b0, "R9");
        read_at(13'h0000, "R9 R8 bank 63 wide, upper lines low");
        write_bank(13'h0040, 1'b0, "R9");
        read_at(13'h1234, "R9 bank 32 wide");
        write_bank(13'h0010, 1'b1, "R3");
        read_at(13'h0000, "R3 unselected write ignored");
        for (int i = 0; i < 4; i++) read_at(13'(i * 2 + 2), "R5 reads in window");
        read_at(13'h0000, "R5 bank unchanged after reads");
        @(negedge clk); inv_mode = 1'b0;
        read_at(13'h0042, "R6 true mode lines");
        @(negedge clk); inv_mode = 1'b1;
        repeat (50) @(negedge clk);
        read_at(13'h0042, "R10 bank held, mode toggle harmless");
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin : finisher
        fork
            wait (done);
            begin
                #(8 * 200000);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule